// File: doc/BRIEF.md
# Port change interrupt detector

This block watches sixteen synchronized port levels and drives an active-low interrupt whenever any of them differs from a stored reference pattern. The reference pattern is a snapshot of the port levels, taken each time the bus controller reports the acknowledge slot of a read or a write that selected this device. A level that moves in either direction pulls the interrupt low. A level that moves back to its snapshot value releases the interrupt again, with no bus access.

The bus controller supplies two one-cycle strobes. One marks the read acknowledge, taken at the rising clock edge of that slot. The other marks the write acknowledge, taken at the falling edge. A hit qualifier comes with them, and a strobe only counts while it is high, so traffic to other devices on the bus leaves the state untouched. A port change that lands in the same cycle as an accepted strobe is taken into the new snapshot and is not reported. Any later change is reported as usual.

Top module: `port_change_irq`

## Requirements
- R1: On reset the interrupt output is high and the snapshot is all ones: with every port level at 1 the output stays high, and any level at 0 pulls it low on the following clock.
- R2: A 0-to-1 change on any single port bit, relative to the snapshot, drives the interrupt output low on the clock edge after the change is presented.
- R3: A 1-to-0 change on any single port bit, relative to the snapshot, drives the interrupt output low on the clock edge after the change is presented.
- R4: When every port level returns to the snapshot value, the interrupt output goes high on the next clock edge, with no strobe needed.
- R5: A read-acknowledge strobe with the hit qualifier high loads the present port levels into the snapshot, and the interrupt output is high on the next clock edge.
- R6: A write-acknowledge strobe with the hit qualifier high loads the present port levels into the snapshot, and the interrupt output is high on the next clock edge.
- R7: Either strobe with the hit qualifier low has no effect: the interrupt output keeps following the comparison against the old snapshot.
- R8: A port change presented in the same cycle as an accepted strobe goes into the snapshot and raises no interrupt. Restoring the earlier levels afterwards then raises one.
- R9: After a strobe has re-armed the detector, any further change of a port bit is detected and drives the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_lvl | input | 16 | Synchronized port pin levels |
| rd_ack_stb | input | 1 | One-cycle strobe at the read acknowledge slot |
| wr_ack_stb | input | 1 | One-cycle strobe at the write acknowledge slot |
| acc_hit | input | 1 | High when the current transfer selects this device |
| irq_n | output | 1 | Active-low interrupt, low while levels differ from the snapshot |

## Verification
A port change and a snapshot load can fall in the same cycle. This is the case where a change is lost. The bench provokes it by presenting new port levels on the very cycle it raises an accepted strobe. It judges the result by two observations: the interrupt stays high on the following edge, and going back to the earlier levels now raises the interrupt, which shows that the new levels were the ones captured. The bench also raises strobes with the qualifier low while a mismatch is pending. It then confirms that the old snapshot still governs the output.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int unsigned PCD_W = 16;

    typedef struct packed {
        logic [PCD_W-1:0] snap;
        logic             irq_n;
    } pcd_state_t;

endpackage

// File: rtl/pcd_clear_qual.sv
// Turns the two acknowledge strobes into one snapshot-load enable.
// A strobe counts only while the hit qualifier marks this device.
module pcd_clear_qual (
    input  logic rd_ack_stb,
    input  logic wr_ack_stb,
    input  logic acc_hit,
    output logic load_en
);
    logic any_stb;

    always_comb begin
        any_stb = rd_ack_stb | wr_ack_stb;
        load_en = any_stb & acc_hit;
    end
endmodule

// File: rtl/pcd_diff.sv
// Compares each port level with its reference bit and gives the
// per-bit mismatch vector and its OR.
module pcd_diff #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] ref_v,
    output logic [W-1:0] diff_vec,
    output logic         any_diff
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            assign diff_vec[gi] = lvl[gi] ^ ref_v[gi];
        end
    endgenerate

    assign any_diff = |diff_vec;
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import pcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PCD_W-1:0] port_lvl,
    input  logic             rd_ack_stb,
    input  logic             wr_ack_stb,
    input  logic             acc_hit,
    output logic             irq_n
);
    localparam logic [PCD_W-1:0] SNAP_RST = {PCD_W{1'b1}};

    pcd_state_t       st_d, st_q;
    logic             load_en;
    logic [PCD_W-1:0] snap_nxt;
    logic [PCD_W-1:0] diff_vec;
    logic             any_diff;

    pcd_clear_qual u_qual (
        .rd_ack_stb (rd_ack_stb),
        .wr_ack_stb (wr_ack_stb),
        .acc_hit    (acc_hit),
        .load_en    (load_en)
    );

    // Reference seen by the comparator: the levels being captured on a load
    always_comb begin
        snap_nxt = load_en ? port_lvl : st_q.snap;
    end

    pcd_diff #(.W(PCD_W)) u_diff (
        .lvl      (port_lvl),
        .ref_v    (snap_nxt),
        .diff_vec (diff_vec),
        .any_diff (any_diff)
    );

    always_comb begin
        st_d       = st_q;
        st_d.snap  = snap_nxt;
        st_d.irq_n = ~any_diff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.snap  <= SNAP_RST;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = st_q.irq_n;
endmodule

// File: rtl/port_change_irq_chk.sv
module port_change_irq_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] port_lvl,
    input logic         rd_ack_stb,
    input logic         wr_ack_stb,
    input logic         acc_hit,
    input logic         irq_n,
    input logic [W-1:0] snap
);
    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R5: accepted read strobe releases the interrupt
    p_rd_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack_stb && acc_hit) |=> irq_n);

    // R6: accepted write strobe releases the interrupt
    p_wr_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack_stb && acc_hit) |=> irq_n);

    // R7: unselected traffic leaves the snapshot alone
    p_miss_keeps_snap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_hit && (rd_ack_stb || wr_ack_stb)) |=> $stable(snap));

    // R4: levels equal to the snapshot keep the line released
    p_match_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_lvl == snap) |=> irq_n);

    // R2 / R3: a mismatch with no load pulls the line low
    p_mismatch_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_lvl != snap) && !(acc_hit && (rd_ack_stb || wr_ack_stb))) |=> !irq_n);

    // R1: with steady levels and no strobes, the output holds
    p_steady_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && $stable(port_lvl) && !rd_ack_stb && !wr_ack_stb
         && !$past(rd_ack_stb) && !$past(wr_ack_stb)) |=> $stable(irq_n));
endmodule

bind port_change_irq port_change_irq_chk #(.W(pcd_pkg::PCD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_lvl   (port_lvl),
    .rd_ack_stb (rd_ack_stb),
    .wr_ack_stb (wr_ack_stb),
    .acc_hit    (acc_hit),
    .irq_n      (irq_n),
    .snap       (st_q.snap)
);

// File: tb/port_change_irq_tb_top.sv
`timescale 1ns/1ps
module port_change_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] port_lvl = 16'hFFFF;
    logic        rd_ack_stb = 1'b0;
    logic        wr_ack_stb = 1'b0;
    logic        acc_hit = 1'b0;
    logic        irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    port_change_irq dut_i (
        .clk(clk), .rst_n(rst_n), .port_lvl(port_lvl),
        .rd_ack_stb(rd_ack_stb), .wr_ack_stb(wr_ack_stb),
        .acc_hit(acc_hit), .irq_n(irq_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (irq_n !== exp) begin
            n_fail++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, irq_n, exp);
        end
    endtask

    // drive levels, wait one edge, compare
    task automatic set_lvl(input logic [15:0] v, input string req, input logic exp);
        port_lvl = v;
        tick();
        check(req, exp);
    endtask

    // strobe: 0 read, 1 write; levels presented together with the strobe
    task automatic strobe(input bit wr, input bit hit, input logic [15:0] v);
        port_lvl   = v;
        acc_hit    = hit;
        rd_ack_stb = !wr;
        wr_ack_stb = wr;
        tick();
        rd_ack_stb = 1'b0;
        wr_ack_stb = 1'b0;
        acc_hit    = 1'b0;
    endtask

    task automatic t_reset();
        tick();
        check("R1", 1'b1);
        set_lvl(16'hFFFF, "R1", 1'b1);
        set_lvl(16'hFFFE, "R1", 1'b0);
        set_lvl(16'hFFFF, "R4", 1'b1);
    endtask

    task automatic t_read_rearm();
        set_lvl(16'h0000, "R3", 1'b0);
        strobe(1'b0, 1'b1, 16'h0000);
        check("R5", 1'b1);
        set_lvl(16'h8000, "R2", 1'b0);
        set_lvl(16'h0000, "R4", 1'b1);
    endtask

    task automatic t_write_rearm();
        set_lvl(16'h1234, "R2", 1'b0);
        strobe(1'b1, 1'b1, 16'h1234);
        check("R6", 1'b1);
        set_lvl(16'h1235, "R9", 1'b0);
        set_lvl(16'h1234, "R9", 1'b1);
    endtask

    task automatic t_other_device();
        port_lvl = 16'h5555;
        tick();
        check("R7", 1'b0);
        strobe(1'b0, 1'b0, 16'h5555);
        check("R7", 1'b0);
        strobe(1'b1, 1'b0, 16'h5555);
        check("R7", 1'b0);
        set_lvl(16'h1234, "R7", 1'b1);
    endtask

    task automatic t_coincident();
        strobe(1'b0, 1'b1, 16'hA5A5);
        check("R8", 1'b1);
        tick();
        check("R8", 1'b1);
        set_lvl(16'h1234, "R8", 1'b0);
    endtask

    task automatic t_walk();
        for (int i = 0; i < 16; i++) begin
            strobe(1'b1, 1'b1, 16'h0F0F);
            check("R6", 1'b1);
            port_lvl = 16'h0F0F ^ (16'h1 << i);
            tick();
            check(((16'h0F0F >> i) & 1) ? "R3" : "R2", 1'b0);
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) tick();
                rst_n = 1'b1;
                t_reset();
                t_read_rearm();
                t_write_rearm();
                t_other_device();
                t_coincident();
                t_walk();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL watchdog expired");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule